// File: doc/BRIEF.md
# E1 Frame Alignment Monitor

This block watches the framing words of an E1 (PCM30) receive stream whose frame position is already known. An upstream framer presents time slot 0 of each frame as one octet, with a flag that says whether the frame is an alignment frame or a non-alignment frame. Separately, the framer presents the time slot 16 octet taken from frame zero of each signalling multiframe.

In alignment frames the block compares the seven-bit alignment pattern and pulses an error when the pattern is wrong. It keeps a run count of back-to-back pattern errors and raises a loss alarm when two come in a row. In non-alignment frames it extracts the non-alignment bit, presents it on an output and flags it when it is zero. It also checks the four-bit multiframe pattern. A saturating count of alignment pattern errors is available for performance monitoring.

Top module: `e1FrameAlignMon`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `fawErr`, `nfasErr` and `mfErr` are 0, `alarm` is 0, `errCount` is 0 and `nonAlignBit` is 1.
- R2: In the cycle after `ts0Valid`=1 with `ts0IsFas`=1, `fawErr` is 1 exactly when `ts0Octet[6:0]` (bits 2 to 8, bit 1 being `ts0Octet[7]`, sent first) differs from 7'b0011011. `ts0Octet[7]` has no effect.
- R3: In the cycle after `ts0Valid`=1 with `ts0IsFas`=0, `nonAlignBit` equals `ts0Octet[6]` (bit 2) and holds that value until the next such frame. A non-alignment frame never raises `fawErr`.
- R4: In the cycle after a non-alignment frame whose `ts0Octet[6]` is 0, `nfasErr` is 1. Otherwise it is 0.
- R5: In the cycle after `ts16Valid`=1, `mfErr` is 1 exactly when `ts16Octet[7:4]` (bits 1 to 4) differs from 4'b0000. `ts16Octet[3:0]` has no effect. The time slot 16 input is independent of the time slot 0 input.
- R6: `alarm` goes to 1 in the same cycle as the `fawErr` pulse of the second consecutive erroneous alignment word. Non-alignment frames between the two do not break the run. Further errors keep `alarm` at 1.
- R7: A correct alignment word clears the run of errors. In the cycle after it, `alarm` is 0.
- R8: `errCount` increases by one in the same cycle as each `fawErr` pulse and stops at 15 (2^CNT_W-1, CNT_W=4).
- R9: In a cycle after one with no valid input, all three error pulses are 0 and `alarm`, `errCount` and `nonAlignBit` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ts0Valid | input | 1 | Time slot 0 octet present this cycle |
| ts0IsFas | input | 1 | 1: alignment frame, 0: non-alignment frame |
| ts0Octet | input | 8 | Time slot 0 octet, bit 1 in [7] |
| ts16Valid | input | 1 | Time slot 16 octet of multiframe frame zero present |
| ts16Octet | input | 8 | Time slot 16 octet, bit 1 in [7] |
| fawErr | output | 1 | Alignment pattern error pulse |
| nfasErr | output | 1 | Non-alignment bit error pulse |
| mfErr | output | 1 | Multiframe pattern error pulse |
| nonAlignBit | output | 1 | Last extracted non-alignment bit |
| alarm | output | 1 | Consecutive alignment error alarm |
| errCount | output | CNT_W | Saturating alignment error count |

## Verification
The assertions check on every cycle that each error pulse follows a valid input of the matching kind, that the alarm only rises together with a pattern error pulse, and that a correct alignment word drops it. They also check that the error count steps by one per pulse, stops at its ceiling and stays still over idle cycles. Only the bench scenarios show that each pulse appears for exactly the octet values that deviate, over all 256 values of each input. The bench also covers the extracted bit tracking the line, the run being bridged by non-alignment frames and broken by a correct word, and the count reaching saturation.

// File: rtl/e1FrameAlignMonPkg.sv
package e1FrameAlignMonPkg;

  // Result of the pattern comparators, datapath to control
  typedef struct packed {
    logic fasMatch;
    logic nfasBitVal;
    logic mfMatch;
  } cmpRes_t;

  // Per-cycle strobes, control to datapath
  typedef struct packed {
    logic fawErr;
    logic fawOk;
    logic nfasLoad;
    logic nfasErr;
    logic mfErr;
  } strobes_t;

endpackage

// File: rtl/e1FrameAlignMonDatapath.sv
module e1FrameAlignMonDatapath
  import e1FrameAlignMonPkg::*;
#(
  parameter int         CNT_W       = 4,
  parameter logic [6:0] FAS_PATTERN = 7'b0011011,
  parameter logic [3:0] MF_PATTERN  = 4'b0000,
  parameter int         FAS_BITS    = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       ts0Octet,
  input  logic [7:0]       ts16Octet,
  input  strobes_t         strobes,
  output cmpRes_t          cmpRes,
  output logic             nonAlignBit,
  output logic [CNT_W-1:0] errCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               MF_BITS = 4;

  logic [FAS_BITS-1:0] fasDiff;
  logic [MF_BITS-1:0]  mfDiff;

  // bitwise comparison, bit 1 of the octet sits in [7] and is not part of the word
  for (genvar i = 0; i < FAS_BITS; i++) begin : g_fasCmp
    assign fasDiff[i] = ts0Octet[i] ^ FAS_PATTERN[i];
  end

  for (genvar j = 0; j < MF_BITS; j++) begin : g_mfCmp
    assign mfDiff[j] = ts16Octet[j+4] ^ MF_PATTERN[j];
  end

  always_comb begin
    cmpRes.fasMatch   = ~|fasDiff;
    cmpRes.mfMatch    = ~|mfDiff;
    cmpRes.nfasBitVal = ts0Octet[6];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nonAlignBit <= 1'b1;
    end else if (strobes.nfasLoad) begin
      nonAlignBit <= cmpRes.nfasBitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCount <= '0;
    end else if (strobes.fawErr && errCount != CNT_MAX) begin
      errCount <= errCount + 1'b1;
    end
  end

endmodule

// File: rtl/e1FrameAlignMonControl.sv
module e1FrameAlignMonControl
  import e1FrameAlignMonPkg::*;
#(
  parameter int         ALARM_RUN   = 2,
  parameter logic       NFAS_EXPECT = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ts0Valid,
  input  logic     ts0IsFas,
  input  logic     ts16Valid,
  input  cmpRes_t  cmpRes,
  output strobes_t strobes,
  output logic     fawErr,
  output logic     nfasErr,
  output logic     mfErr,
  output logic     alarm
);

  localparam int RUN_W = $clog2(ALARM_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ALARM_RUN);

  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runNext;

  always_comb begin
    strobes.fawErr   = ts0Valid &&  ts0IsFas && !cmpRes.fasMatch;
    strobes.fawOk    = ts0Valid &&  ts0IsFas &&  cmpRes.fasMatch;
    strobes.nfasLoad = ts0Valid && !ts0IsFas;
    strobes.nfasErr  = ts0Valid && !ts0IsFas && (cmpRes.nfasBitVal != NFAS_EXPECT);
    strobes.mfErr    = ts16Valid && !cmpRes.mfMatch;
  end

  always_comb begin
    runNext = runCnt;
    if (strobes.fawOk) begin
      runNext = '0;
    end else if (strobes.fawErr && runCnt != RUN_MAX) begin
      runNext = runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      alarm   <= 1'b0;
      fawErr  <= 1'b0;
      nfasErr <= 1'b0;
      mfErr   <= 1'b0;
    end else begin
      runCnt  <= runNext;
      alarm   <= (runNext >= RUN_MAX);
      fawErr  <= strobes.fawErr;
      nfasErr <= strobes.nfasErr;
      mfErr   <= strobes.mfErr;
    end
  end

endmodule

// File: rtl/e1FrameAlignMon.sv
module e1FrameAlignMon
  import e1FrameAlignMonPkg::*;
#(
  parameter int         CNT_W       = 4,
  parameter int         ALARM_RUN   = 2,
  parameter logic [6:0] FAS_PATTERN = 7'b0011011,
  parameter logic [3:0] MF_PATTERN  = 4'b0000,
  parameter logic       NFAS_EXPECT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ts0Valid,
  input  logic             ts0IsFas,
  input  logic [7:0]       ts0Octet,
  input  logic             ts16Valid,
  input  logic [7:0]       ts16Octet,
  output logic             fawErr,
  output logic             nfasErr,
  output logic             mfErr,
  output logic             nonAlignBit,
  output logic             alarm,
  output logic [CNT_W-1:0] errCount
);

  cmpRes_t  cmpRes;
  strobes_t strobes;

  e1FrameAlignMonDatapath #(
    .CNT_W       (CNT_W),
    .FAS_PATTERN (FAS_PATTERN),
    .MF_PATTERN  (MF_PATTERN),
    .FAS_BITS    (7)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ts0Octet    (ts0Octet),
    .ts16Octet   (ts16Octet),
    .strobes     (strobes),
    .cmpRes      (cmpRes),
    .nonAlignBit (nonAlignBit),
    .errCount    (errCount)
  );

  e1FrameAlignMonControl #(
    .ALARM_RUN   (ALARM_RUN),
    .NFAS_EXPECT (NFAS_EXPECT)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .ts0Valid  (ts0Valid),
    .ts0IsFas  (ts0IsFas),
    .ts16Valid (ts16Valid),
    .cmpRes    (cmpRes),
    .strobes   (strobes),
    .fawErr    (fawErr),
    .nfasErr   (nfasErr),
    .mfErr     (mfErr),
    .alarm     (alarm)
  );

endmodule

// File: rtl/e1FrameAlignMonChk.sv
module e1FrameAlignMonChk #(
  parameter int         CNT_W       = 4,
  parameter logic [6:0] FAS_PATTERN = 7'b0011011
) (
  input logic             clk,
  input logic             rstN,
  input logic             ts0Valid,
  input logic             ts0IsFas,
  input logic [7:0]       ts0Octet,
  input logic             ts16Valid,
  input logic             fawErr,
  input logic             nfasErr,
  input logic             mfErr,
  input logic             nonAlignBit,
  input logic             alarm,
  input logic [CNT_W-1:0] errCount
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  AST_FAW_AFTER_FAS: assert property (@(posedge clk) disable iff (!rstN)
    fawErr |-> $past(ts0Valid && ts0IsFas)) else $error("AST_FAW_AFTER_FAS"); // R2

  AST_NO_DOUBLE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(fawErr && nfasErr)) else $error("AST_NO_DOUBLE_KIND"); // R3

  AST_NFAS_ERR_BIT: assert property (@(posedge clk) disable iff (!rstN)
    nfasErr |-> (!nonAlignBit && $past(ts0Valid && !ts0IsFas))) else $error("AST_NFAS_ERR_BIT"); // R4

  AST_MF_AFTER_TS16: assert property (@(posedge clk) disable iff (!rstN)
    mfErr |-> $past(ts16Valid)) else $error("AST_MF_AFTER_TS16"); // R5

  AST_ALARM_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarm) |-> fawErr) else $error("AST_ALARM_RISE"); // R6

  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ts0Valid && ts0IsFas && ts0Octet[6:0] == FAS_PATTERN) |=> !alarm) else $error("AST_ALARM_CLEAR"); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    fawErr |-> (errCount == $past(errCount) + 1'b1 || ($past(errCount) == CNT_TOP && errCount == CNT_TOP)))
    else $error("AST_COUNT_STEP"); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ts0Valid) |-> ($stable(errCount) && $stable(alarm) && $stable(nonAlignBit) && !fawErr && !nfasErr))
    else $error("AST_IDLE_HOLD"); // R9

endmodule

bind e1FrameAlignMon e1FrameAlignMonChk #(
  .CNT_W       (CNT_W),
  .FAS_PATTERN (FAS_PATTERN)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ts0Valid    (ts0Valid),
  .ts0IsFas    (ts0IsFas),
  .ts0Octet    (ts0Octet),
  .ts16Valid   (ts16Valid),
  .fawErr      (fawErr),
  .nfasErr     (nfasErr),
  .mfErr       (mfErr),
  .nonAlignBit (nonAlignBit),
  .alarm       (alarm),
  .errCount    (errCount)
);

// File: tb/e1FrameAlignMon_bench.sv
`timescale 1ns/1ps
module e1FrameAlignMon_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ts0Valid = 1'b0;
  logic       ts0IsFas = 1'b0;
  logic [7:0] ts0Octet = 8'h00;
  logic       ts16Valid = 1'b0;
  logic [7:0] ts16Octet = 8'h00;
  logic       fawErr, nfasErr, mfErr, nonAlignBit, alarm;
  logic [3:0] errCount;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  // reference model state
  int  mRun = 0;
  int  mCnt = 0;
  bit  mNab = 1'b1;

  always #4 clk = ~clk;

  e1FrameAlignMon u_e1FrameAlignMon (
    .clk(clk), .rstN(rstN), .ts0Valid(ts0Valid), .ts0IsFas(ts0IsFas),
    .ts0Octet(ts0Octet), .ts16Valid(ts16Valid), .ts16Octet(ts16Octet),
    .fawErr(fawErr), .nfasErr(nfasErr), .mfErr(mfErr),
    .nonAlignBit(nonAlignBit), .alarm(alarm), .errCount(errCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, update the model from the requirements, check at the next negedge
  task automatic step(input bit v0, input bit isFas, input logic [7:0] o0,
                      input bit v16, input logic [7:0] o16);
    bit eFaw, eNfas, eMf;
    ts0Valid = v0; ts0IsFas = isFas; ts0Octet = o0;
    ts16Valid = v16; ts16Octet = o16;
    eFaw  = v0 && isFas && (o0[6:0] != 7'b0011011);
    eNfas = v0 && !isFas && !o0[6];
    eMf   = v16 && (o16[7:4] != 4'b0000);
    if (v0 && !isFas) mNab = o0[6];
    if (v0 && isFas) begin
      if (eFaw) begin
        if (mRun < 2) mRun++;
        if (mCnt < 15) mCnt++;
      end else begin
        mRun = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    ts0Valid = 1'b0; ts16Valid = 1'b0;
    check("R2 fawErr", fawErr, eFaw);
    check("R4 nfasErr", nfasErr, eNfas);
    check("R5 mfErr", mfErr, eMf);
    check("R3 nonAlignBit", nonAlignBit, mNab);
    check("R6/R7 alarm", alarm, (mRun >= 2));
    check("R8 errCount", errCount, mCnt);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    mRun = 0; mCnt = 0; mNab = 1'b1;
    repeat (2) @(negedge clk);
    // R1: values while reset is held
    check("R1 fawErr", fawErr, 0);
    check("R1 nfasErr", nfasErr, 0);
    check("R1 mfErr", mfErr, 0);
    check("R1 alarm", alarm, 0);
    check("R1 errCount", errCount, 0);
    check("R1 nonAlignBit", nonAlignBit, 1);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    step(0, 0, 8'h00, 0, 8'h00); // R1: first cycle after reset, R9: idle

    // R2: every alignment octet value, each followed by a correct word
    for (int v = 0; v < 256; v++) begin
      step(1, 1, 8'(v), 0, 8'h00);
      step(1, 1, 8'h1B, 0, 8'h00);
    end
    // R3, R4: every non-alignment octet value
    for (int v = 0; v < 256; v++) step(1, 0, 8'(v), 0, 8'h00);
    // R5: every time slot 16 value, alongside time slot 0 traffic
    for (int v = 0; v < 256; v++) step((v % 3) == 0, v[0], 8'(v ^ 8'h5A), 1, 8'(v));

    // R6, R7: alarm sequences
    doReset();
    step(1, 1, 8'h00, 0, 8'h00);   // first error, no alarm
    step(1, 0, 8'h40, 0, 8'h00);   // R6: non-alignment frame does not break run
    step(0, 0, 8'h00, 0, 8'h00);   // R9: idle holds
    step(1, 1, 8'h9B ^ 8'h01, 0, 8'h00); // second error, alarm rises
    step(1, 1, 8'hFF, 0, 8'h00);   // R6: stays
    step(1, 1, 8'h9B, 0, 8'h00);   // R7: bit 1 ignored, correct word clears
    step(1, 1, 8'h1A, 0, 8'h00);   // error
    step(1, 1, 8'h1B, 0, 8'h00);   // R7: correct breaks run
    step(1, 1, 8'h3B, 0, 8'h00);   // error, no alarm
    step(1, 1, 8'h1B, 0, 8'h00);

    // R8: saturation of the error count
    doReset();
    for (int k = 0; k < 20; k++) step(1, 1, 8'(k + 1), 0, 8'h00);
    // R9: idle cycles hold state
    for (int k = 0; k < 4; k++) step(0, 1, 8'h00, 0, 8'hF0);
    step(1, 1, 8'h1B, 0, 8'h00);
    check("R8 errCount held at ceiling", errCount, 15);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule